// File: doc/BRIEF.md
# Descriptor Ring Pointer Tracker

This block keeps the addresses that a DMA engine needs while it walks a ring of descriptors in memory. It serves one direction only, so a transmit path and a receive path each get their own instance. Software loads three pointers through a small write port: the first descriptor of the list, the descriptor to fetch next, and the descriptor that finished most recently. It also loads a two-bit code that sets the descriptor size.

While the engine is enabled, the DMA side pulses a completion strobe for each descriptor it finishes, together with that descriptor's end-of-list bit. On that edge the block records the finished address and its end-of-list bit. It then moves the fetch pointer to one of two places. If the end-of-list bit is clear, the pointer steps forward by the descriptor size. If the bit is set, the pointer jumps back to the list start. The ring therefore has no fixed depth. Every output comes straight from a register.

Software sets up a ring while the engine is idle. It writes the list start into both the start register and the fetch register, and it writes the address of the final descriptor into the finished register. A transmit ring must hold enough descriptors for at least five frames. A receive ring may give every descriptor to one frame.

Top module: `desc_ring_ptr`

## Requirements
- R1: After a synchronous reset, the start, fetch and finished pointers are zero, the end-of-list flag is 0 and the size code is 00.
- R2: A write with select 0, 1 or 2 loads the start, fetch or finished pointer respectively. The written value has its low bits cleared: bits [3:0] for 16-byte descriptors, bits [4:0] for 32-byte and bits [5:0] for 64-byte. The new value appears after the clock edge.
- R3: A write with select 3 loads the size code from data bits [1:0]. Code 00 means 16 bytes, 01 means 32, 10 means 64, and 11 is treated as 16.
- R4: A completion strobe with the end-of-list bit at 0, taken while enabled, sets the fetch pointer to the old fetch pointer plus the descriptor size, modulo 2^32.
- R5: A completion strobe with the end-of-list bit at 1, taken while enabled, sets the fetch pointer to the start pointer.
- R6: On the same edge as an accepted completion, the finished pointer takes the old fetch pointer and the end-of-list flag takes the strobe's end-of-list bit.
- R7: A completion strobe that arrives while the enable input is low changes none of the pointers and does not change the flag.
- R8: If a software write and an accepted completion target the same pointer in the same cycle, the software value is stored in that pointer. The other pointers still take their completion updates.
- R9: The next-fetch output always equals the fetch pointer.
- R10: A size-code write made while the enable input is high is ignored. Pointer writes are accepted whether or not the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| engine_en | input | 1 | Engine running; completions are accepted only while this is high |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 fetch, 2 finished, 3 size code |
| wr_data | input | 32 | Write data |
| desc_done | input | 1 | Descriptor completion strobe |
| desc_last | input | 1 | End-of-list bit of the completed descriptor |
| list_start | output | 32 | Start-of-list pointer |
| fetch_ptr | output | 32 | Pointer to the descriptor being processed |
| fin_ptr | output | 32 | Pointer to the most recently finished descriptor |
| fin_last | output | 1 | End-of-list bit of the most recently finished descriptor |
| size_code | output | 2 | Descriptor size code |
| next_fetch | output | 32 | Address of the next descriptor to fetch |

## Verification
A software pointer write and an accepted completion can fall on the same edge. Both try to update the fetch and finished pointers, and a start write can race a wrap that reads the start pointer. The bench triggers this by raising the write strobe and the completion strobe in the same cycle. It does this for each of the three pointer selects, with the end-of-list bit at both 0 and 1. A bench model applies the completion first and then overwrites the targeted register with the aligned software value. It compares every output against that model after the edge.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_FETCH = 2'd1,
    SEL_FIN   = 2'd2,
    SEL_SIZE  = 2'd3
  } wsel_e;

  localparam int unsigned BASE_SHIFT = 4;

  function automatic int unsigned size_shift(input logic [1:0] code);
    case (code)
      2'b01:   size_shift = BASE_SHIFT + 1;
      2'b10:   size_shift = BASE_SHIFT + 2;
      default: size_shift = BASE_SHIFT;
    endcase
  endfunction

endpackage

// File: rtl/drp_size_cfg.sv
module drp_size_cfg
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [CODE_W-1:0] ld_code,
  output logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] low_mask
);

  logic [ADDR_W-1:0] one;
  assign one = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)     code <= '0;
    else if (ld) code <= ld_code;
  end

  always_comb begin
    step     = one << size_shift(code[1:0]);
    low_mask = step - one;
  end

endmodule

// File: rtl/drp_next_calc.sv
module drp_next_calc #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] step,
  input  logic              last,
  output logic [ADDR_W-1:0] nxt
);

  always_comb begin
    if (last) nxt = start;
    else      nxt = cur + step;
  end

endmodule

// File: rtl/drp_ptr_bank.sv
module drp_ptr_bank #(
  parameter int ADDR_W = 32,
  parameter int NPTR   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPTR-1:0]             sw_ld,
  input  logic [ADDR_W-1:0]           sw_val,
  input  logic [NPTR-1:0]             hw_ld,
  input  logic [NPTR-1:0][ADDR_W-1:0] hw_val,
  output logic [NPTR-1:0][ADDR_W-1:0] q
);

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= '0;
      else if (sw_ld[i])  q[i] <= sw_val;
      else if (hw_ld[i])  q[i] <= hw_val[i];
    end
  end

endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              engine_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              desc_done,
  input  logic              desc_last,
  output logic [ADDR_W-1:0] list_start,
  output logic [ADDR_W-1:0] fetch_ptr,
  output logic [ADDR_W-1:0] fin_ptr,
  output logic              fin_last,
  output logic [CODE_W-1:0] size_code,
  output logic [ADDR_W-1:0] next_fetch
);

  localparam int NPTR = 3;

  logic                        take_done;
  logic [ADDR_W-1:0]           step, low_mask, nxt, sw_val;
  logic [NPTR-1:0]             sw_ld, hw_ld;
  logic [NPTR-1:0][ADDR_W-1:0] hw_val, ptr_q;

  assign take_done = desc_done & engine_en;

  drp_size_cfg #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .ld       (wr_en && wr_sel == SEL_SIZE && !engine_en),
    .ld_code  (wr_data[CODE_W-1:0]),
    .code     (size_code),
    .step     (step),
    .low_mask (low_mask)
  );

  drp_next_calc #(.ADDR_W(ADDR_W)) u_next (
    .cur   (ptr_q[SEL_FETCH]),
    .start (ptr_q[SEL_START]),
    .step  (step),
    .last  (desc_last),
    .nxt   (nxt)
  );

  always_comb begin
    sw_val = wr_data & ~low_mask;
    for (int i = 0; i < NPTR; i++) sw_ld[i] = wr_en && (wr_sel == 2'(i));
    hw_ld            = '0;
    hw_ld[SEL_FETCH] = take_done;
    hw_ld[SEL_FIN]   = take_done;
    hw_val            = '0;
    hw_val[SEL_FETCH] = nxt;
    hw_val[SEL_FIN]   = ptr_q[SEL_FETCH];
  end

  drp_ptr_bank #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .sw_ld  (sw_ld),
    .sw_val (sw_val),
    .hw_ld  (hw_ld),
    .hw_val (hw_val),
    .q      (ptr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            fin_last <= 1'b0;
    else if (take_done) fin_last <= desc_last;
  end

  assign list_start = ptr_q[SEL_START];
  assign fetch_ptr  = ptr_q[SEL_FETCH];
  assign fin_ptr    = ptr_q[SEL_FIN];
  assign next_fetch = ptr_q[SEL_FETCH];

  AST_STEP_FWD: assert property (@(posedge clk) disable iff (rst)
    (desc_done && engine_en && !desc_last && !(wr_en && wr_sel == SEL_FETCH))
    |=> fetch_ptr == $past(fetch_ptr) + $past(step)); // R4

  AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
    (desc_done && engine_en && desc_last && !(wr_en && wr_sel == SEL_FETCH))
    |=> fetch_ptr == $past(list_start)); // R5

  AST_FIN_RECORD: assert property (@(posedge clk) disable iff (rst)
    (desc_done && engine_en && !(wr_en && wr_sel == SEL_FIN))
    |=> fin_ptr == $past(fetch_ptr) && fin_last == $past(desc_last)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!engine_en && !wr_en)
    |=> $stable(fetch_ptr) && $stable(fin_ptr) && $stable(fin_last)); // R7

  AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_FETCH && desc_done && engine_en)
    |=> fetch_ptr == ($past(wr_data) & ~$past(low_mask))); // R8

  AST_SIZE_LOCK: assert property (@(posedge clk) disable iff (rst)
    engine_en |=> $stable(size_code)); // R10

  AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
    list_start[3:0] == 4'h0); // R2

endmodule

// File: tb/desc_ring_ptr_test.sv
module desc_ring_ptr_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        engine_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        desc_done = 1'b0;
  logic        desc_last = 1'b0;
  logic [31:0] list_start, fetch_ptr, fin_ptr, next_fetch;
  logic        fin_last;
  logic [1:0]  size_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] m_start, m_cur, m_fin;
  logic        m_last;
  logic [1:0]  m_code;

  always #2 clk = ~clk;

  desc_ring_ptr uut (
    .clk(clk), .rst(rst), .engine_en(engine_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .desc_done(desc_done), .desc_last(desc_last),
    .list_start(list_start), .fetch_ptr(fetch_ptr), .fin_ptr(fin_ptr),
    .fin_last(fin_last), .size_code(size_code), .next_fetch(next_fetch)
  );

  function automatic logic [31:0] bytes_of(input logic [1:0] c);
    return (c == 2'b01) ? 32'd32 : (c == 2'b10) ? 32'd64 : 32'd16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " fetch"}, fetch_ptr, m_cur);
    chk({req, " fin"},   fin_ptr,   m_fin);
    chk({req, " flag"},  {31'd0, fin_last}, {31'd0, m_last});
    chk({req, " start"}, list_start, m_start);
    chk({req, " code"},  {30'd0, size_code}, {30'd0, m_code});
    chk("R9 next_fetch", next_fetch, m_cur);
  endtask

  // one cycle: drive at negedge, model update, sample at next negedge
  task automatic cycle(input logic we, input logic [1:0] sel, input logic [31:0] d,
                       input logic dn, input logic lst, input string req);
    logic [31:0] mask, nc;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; desc_done = dn; desc_last = lst;
    mask = bytes_of(m_code) - 32'd1;
    if (dn && engine_en) begin
      nc = lst ? m_start : m_cur + bytes_of(m_code);
      m_fin = m_cur; m_last = lst; m_cur = nc;
    end
    if (we) begin
      case (sel)
        2'd0: m_start = d & ~mask;
        2'd1: m_cur   = d & ~mask;
        2'd2: m_fin   = d & ~mask;
        default: if (!engine_en) m_code = d[1:0];
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; desc_done = 1'b0; desc_last = 1'b0;
    check_all(req);
  endtask

  task automatic setup_ring(input logic [1:0] code, input logic [31:0] base, input logic [31:0] last_addr);
    engine_en = 1'b0;
    cycle(1'b1, 2'd3, {30'd0, code}, 1'b0, 1'b0, "R3 size write");
    cycle(1'b1, 2'd0, base, 1'b0, 1'b0, "R2 start write");
    cycle(1'b1, 2'd1, base, 1'b0, 1'b0, "R2 fetch write");
    cycle(1'b1, 2'd2, last_addr, 1'b0, 1'b0, "R2 fin write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_start = '0; m_cur = '0; m_fin = '0; m_last = 1'b0; m_code = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // ring sweeps over every size code and ring lengths 1..6
    for (int c = 0; c < 4; c++) begin
      for (int n = 1; n <= 6; n++) begin
        logic [31:0] base;
        base = 32'h1000_0007 + 32'(c) * 32'h100 + 32'(n) * 32'h1_0000;
        setup_ring(2'(c), base + 32'(n - 1) * bytes_of(2'(c)), 32'h0);
        // start was written unaligned: model already masked it
        setup_ring(2'(c), base, base + 32'(n - 1) * bytes_of(2'(c)));
        engine_en = 1'b1;
        for (int k = 0; k < 2 * n + 1; k++) begin
          if ((k % n) == n - 1) cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, "R5 wrap to start");
          else                  cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, "R4 step forward");
        end
        cycle(1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R6 hold without strobe");
        cycle(1'b1, 2'd3, {30'd0, 2'(c + 1)}, 1'b0, 1'b0, "R10 size write while enabled");
        engine_en = 1'b0;
        cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, "R7 strobe while disabled");
        cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, "R7 strobe with last while disabled");
      end
    end

    // same-cycle software write and completion, every pointer, both last values
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 2; l++) begin
        setup_ring(2'd1, 32'h2000_0000, 32'h2000_00E0);
        engine_en = 1'b1;
        cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, "R4 step before collision");
        cycle(1'b1, 2'(s), 32'h3000_0055 + 32'(s) * 32'h40, 1'b1, 1'(l), "R8 collision");
        cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, "R5 wrap after collision");
        engine_en = 1'b0;
      end
    end

    // address wrap modulo 2^32
    setup_ring(2'd0, 32'hFFFF_FFF3, 32'hFFFF_FFF0);
    engine_en = 1'b1;
    cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, "R4 wrap modulo 2^32");
    engine_en = 1'b0;

    // code 11 behaves as 16 bytes, mask and step
    setup_ring(2'd3, 32'h4000_003F, 32'h4000_0030);
    engine_en = 1'b1;
    cycle(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, "R3 code 11 step 16");
    engine_en = 1'b0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule